// File: doc/BRIEF.md
# USB Endpoint Handshake Flag Controller

This block decides the handshake reply for every token a serial interface engine decodes, for a small USB device function with a control endpoint 0 and two more endpoints (1 and 2) that share one transmit path. It also holds the completion, end-of-packet and resume flags, the per-path enable bits, a stall bit and an interrupt mask, all in a small CPU register window.

A token arrives as a one-cycle strobe with a direction and an endpoint number. One cycle later the block presents its reply: DATA, ACK, NAK or STALL. When it answers DATA or ACK, the transaction stays pending. It completes when the host's ACK (for IN) or a correctly received data packet (for OUT) follows. Completion sets the path's done flag and drops its enable. While the flag stays set, or the enable stays low, later tokens to that path get NAK. Software clears a flag by writing 1 to it.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After a DATA reply to IN on endpoint 0, a `host_ack_i` pulse sets flag bit 0 (register 0) and clears enable bit 0 (register 1).
- R2: IN to endpoint 0 gets DATA when enable bit 0 is 1 and flag bit 0 is 0. Otherwise it gets NAK.
- R3: OUT to endpoint 0 gets ACK when enable bit 1 is 1 and flag bit 1 is 0, and NAK otherwise. After that ACK, an `rx_ok_i` pulse sets flag bit 1 and clears enable bit 1.
- R4: Endpoints 1 and 2 share flag bit 2 and enable bit 2. IN to either endpoint behaves as in R1/R2 on those bits. OUT to endpoint 1 or 2 gets NAK. A token to endpoint 3 gets no reply.
- R5: `eop_i` sets flag bit 3, which stays set until software clears it.
- R6: `bus_act_i` sets flag bit 4 only while `suspend_i` is 1.
- R7: With stall bit 3 of register 1 set, every token to endpoint 0 gets STALL. STALL takes priority over NAK, DATA and ACK.
- R8: A reply is valid in the cycle after its token. The codes are DATA=1, ACK=2, NAK=3, STALL=4.
- R9: `irq_o` is the OR of the flags, each ANDed with its bit in register 2. It follows a flag change one cycle later.
- R10: Reset clears all flags, enables, the stall bit, the mask and `irq_o`.
- R11: Writing 1 to a bit of register 0 clears that flag. A hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tok_valid_i | input | 1 | token strobe |
| tok_in_i | input | 1 | 1 = IN, 0 = OUT |
| tok_ep_i | input | 2 | endpoint number |
| host_ack_i | input | 1 | host ACK received after sent data |
| rx_ok_i | input | 1 | OUT data packet received correctly |
| eop_i | input | 1 | valid end of packet seen |
| bus_act_i | input | 1 | bus activity detected |
| suspend_i | input | 1 | device in suspend |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 2 | register select: 0 flags, 1 control, 2 mask |
| reg_wdata_i | input | 8 | write data |
| reg_rdata_o | output | 8 | read data |
| reply_valid_o | output | 1 | reply strobe |
| reply_o | output | 3 | reply code |
| irq_o | output | 1 | masked interrupt |

## Verification
A flag or enable held in the wrong state shows up as a wrong reply code on the very next token to that path. It is also visible at once when register 0 or 1 is read. A lost pending record shows up as a missing flag in the cycle after the host ACK or receive pulse. A mask fault shows on `irq_o` one cycle after the flag changes. The sweep covers every direction, endpoint, stall and enable combination, before and after completion.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  localparam int unsigned N_FLAG = 5;
  localparam int unsigned N_CTRL = 4;
  localparam int unsigned F_TX0  = 0;
  localparam int unsigned F_RX0  = 1;
  localparam int unsigned F_TX12 = 2;
  localparam int unsigned F_EOP  = 3;
  localparam int unsigned F_RES  = 4;
  localparam int unsigned C_STALL = 3;

  typedef enum logic [2:0] {
    REPLY_NONE  = 3'd0,
    REPLY_DATA  = 3'd1,
    REPLY_ACK   = 3'd2,
    REPLY_NAK   = 3'd3,
    REPLY_STALL = 3'd4
  } reply_e;
endpackage

// File: rtl/usb_hs_w1c_flag.sv
module usb_hs_w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set wins over clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/usb_hs_reply.sv
module usb_hs_reply
  import usb_hs_pkg::*;
#(
  parameter int unsigned EP_W = 2
) (
  input  logic            tok_in_i,
  input  logic [EP_W-1:0] tok_ep_i,
  input  logic [N_CTRL-1:0] ctrl_i,
  input  logic [N_FLAG-1:0] flag_i,
  output reply_e          reply_o,
  output logic            has_reply_o
);
  localparam logic [EP_W-1:0] EP_LAST = 2'd2;

  logic ep0, ep12;
  assign ep0  = (tok_ep_i == '0);
  assign ep12 = !ep0 && (tok_ep_i <= EP_LAST);
  assign has_reply_o = ep0 || ep12;

  always_comb begin
    reply_o = REPLY_NONE;
    if (ep0) begin
      if (ctrl_i[C_STALL]) reply_o = REPLY_STALL;
      else if (tok_in_i)
        reply_o = (ctrl_i[F_TX0] && !flag_i[F_TX0]) ? REPLY_DATA : REPLY_NAK;
      else
        reply_o = (ctrl_i[F_RX0] && !flag_i[F_RX0]) ? REPLY_ACK : REPLY_NAK;
    end else if (ep12) begin
      if (tok_in_i)
        reply_o = (ctrl_i[F_TX12] && !flag_i[F_TX12]) ? REPLY_DATA : REPLY_NAK;
      else
        reply_o = REPLY_NAK;
    end
  end
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
  import usb_hs_pkg::*;
#(
  parameter int unsigned EP_W   = 2,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic              tok_in_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              host_ack_i,
  input  logic              rx_ok_i,
  input  logic              eop_i,
  input  logic              bus_act_i,
  input  logic              suspend_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reply_valid_o,
  output logic [2:0]        reply_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_FLAG = 'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 'd2;

  logic [N_FLAG-1:0] flag_q, flag_set, flag_clr, mask_q;
  logic [N_CTRL-1:0] ctrl_q;
  reply_e            rep, reply_q;
  logic              has_rep, reply_valid_q, irq_q;
  logic              pend_q, pend_in_q, pend_ep12_q;
  logic              in_done, out_done;

  usb_hs_reply #(.EP_W(EP_W)) i_reply (
    .tok_in_i   (tok_in_i),
    .tok_ep_i   (tok_ep_i),
    .ctrl_i     (ctrl_q),
    .flag_i     (flag_q),
    .reply_o    (rep),
    .has_reply_o(has_rep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reply_valid_q <= 1'b0;
      reply_q       <= REPLY_NONE;
    end else begin
      reply_valid_q <= tok_valid_i && has_rep;
      reply_q       <= tok_valid_i ? rep : REPLY_NONE;
    end
  end

  // pending transaction awaiting host ACK or good OUT data
  assign in_done  = host_ack_i && pend_q && pend_in_q;
  assign out_done = rx_ok_i && pend_q && !pend_in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_in_q   <= 1'b0;
      pend_ep12_q <= 1'b0;
    end else if (tok_valid_i) begin
      pend_q      <= (rep == REPLY_DATA) || (rep == REPLY_ACK);
      pend_in_q   <= tok_in_i;
      pend_ep12_q <= (tok_ep_i != '0);
    end else if (in_done || out_done) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_TX0]  = in_done && !pend_ep12_q;
    flag_set[F_RX0]  = out_done;
    flag_set[F_TX12] = in_done && pend_ep12_q;
    flag_set[F_EOP]  = eop_i;
    flag_set[F_RES]  = bus_act_i && suspend_i;
    flag_clr = (reg_we_i && reg_addr_i == A_FLAG) ? reg_wdata_i[N_FLAG-1:0] : '0;
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    usb_hs_w1c_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .q_o   (flag_q[g])
    );
  end

  // enables self-clear on completion; a software write in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i[N_CTRL-1:0];
      else begin
        if (flag_set[F_TX0])  ctrl_q[F_TX0]  <= 1'b0;
        if (flag_set[F_RX0])  ctrl_q[F_RX0]  <= 1'b0;
        if (flag_set[F_TX12]) ctrl_q[F_TX12] <= 1'b0;
      end
      if (reg_we_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[N_FLAG-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_q & mask_q);
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_FLAG:  reg_rdata_o[N_FLAG-1:0] = flag_q;
      A_CTRL:  reg_rdata_o[N_CTRL-1:0] = ctrl_q;
      A_MASK:  reg_rdata_o[N_FLAG-1:0] = mask_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign reply_valid_o = reply_valid_q;
  assign reply_o       = reply_q;
  assign irq_o         = irq_q;
endmodule

// File: rtl/usb_hs_chk.sv
module usb_hs_chk
  import usb_hs_pkg::*;
#(
  parameter int unsigned EP_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tok_valid_i,
  input logic              tok_in_i,
  input logic [EP_W-1:0]   tok_ep_i,
  input logic              host_ack_i,
  input logic              bus_act_i,
  input logic              suspend_i,
  input logic              reply_valid_o,
  input logic [2:0]        reply_o,
  input logic              irq_o,
  input logic [N_FLAG-1:0] flag_q,
  input logic [N_CTRL-1:0] ctrl_q,
  input logic [N_FLAG-1:0] mask_q
);
  assert_stall_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && tok_ep_i == '0 && ctrl_q[C_STALL] |=> reply_valid_o && reply_o == 3'd4);

  assert_tx0_busy_nak_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && tok_in_i && tok_ep_i == '0 && !ctrl_q[C_STALL] && flag_q[F_TX0]
    |=> reply_o == 3'd3);

  assert_reply_after_token_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_valid_o |-> $past(tok_valid_i));

  assert_tx0_needs_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[F_TX0]) |-> $past(host_ack_i));

  assert_resume_in_suspend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[F_RES]) |-> $past(bus_act_i && suspend_i));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((flag_q & mask_q) != '0));
endmodule

bind usb_ep_hs_ctrl usb_hs_chk #(.EP_W(EP_W)) i_usb_hs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tok_valid_i  (tok_valid_i),
  .tok_in_i     (tok_in_i),
  .tok_ep_i     (tok_ep_i),
  .host_ack_i   (host_ack_i),
  .bus_act_i    (bus_act_i),
  .suspend_i    (suspend_i),
  .reply_valid_o(reply_valid_o),
  .reply_o      (reply_o),
  .irq_o        (irq_o),
  .flag_q       (flag_q),
  .ctrl_q       (ctrl_q),
  .mask_q       (mask_q)
);

// File: tb/test_usb_ep_hs_ctrl.sv
module test_usb_ep_hs_ctrl;
  logic       clk_i = 0, rst_ni = 0;
  logic       tok_valid_i = 0, tok_in_i = 0;
  logic [1:0] tok_ep_i = 0;
  logic       host_ack_i = 0, rx_ok_i = 0, eop_i = 0, bus_act_i = 0, suspend_i = 0;
  logic       reg_we_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o;
  logic       reply_valid_o, irq_o;
  logic [2:0] reply_o;
  int n_chk = 0, n_fail = 0;

  usb_ep_hs_ctrl i_usb_ep_hs_ctrl (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic token(input logic dir, input logic [1:0] ep);
    @(negedge clk_i); tok_valid_i = 1; tok_in_i = dir; tok_ep_i = ep;
    @(negedge clk_i); tok_valid_i = 0;
  endtask

  task automatic complete(input logic dir);
    @(negedge clk_i); if (dir) host_ack_i = 1; else rx_ok_i = 1;
    @(negedge clk_i); host_ack_i = 0; rx_ok_i = 0;
  endtask

  function automatic int model(input bit dir, input int ep, input bit stall, input bit en,
                               input bit busy);
    if (ep == 3) return 0;
    if (ep == 0 && stall) return 4;
    if (!dir && ep != 0) return 3;
    if (!en || busy) return 3;
    return dir ? 1 : 2;
  endfunction

  initial begin
    logic [7:0] d;
    int e, bitn;
    repeat (3) @(negedge clk_i);
    rd(0, d); chk("R10 flags", d, 0);
    rd(1, d); chk("R10 ctrl", d, 0);
    rd(2, d); chk("R10 mask", d, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 reply_valid", reply_valid_o, 0);
    rst_ni = 1;

    // R2 R3 R4 R7 R8 sweep
    for (int dir = 0; dir < 2; dir++)
      for (int ep = 0; ep < 4; ep++)
        for (int st = 0; st < 2; st++)
          for (int en = 0; en < 2; en++) begin
            wr(0, 8'h1F);
            wr(1, {4'd0, st[0], en[0] ? 3'b111 : 3'b000});
            token(dir[0], ep[1:0]);
            e = model(dir[0], ep, st[0], en[0], 0);
            chk("R8 R7 R4 valid", reply_valid_o, ep != 3);
            chk("R2 R3 R4 R7 reply", reply_o, e);
            if (e == 1 || e == 2) begin
              bitn = (ep != 0) ? 2 : (dir ? 0 : 1);
              complete(dir[0]);
              rd(0, d); chk("R1 R3 R4 flag set", d[bitn], 1);
              rd(1, d); chk("R1 R3 R4 enable cleared", d[bitn], 0);
              token(dir[0], ep[1:0]);
              chk("R2 R3 R4 nak after done", reply_o, 3);
              wr(1, 8'h07);
              token(dir[0], ep[1:0]);
              chk("R2 R3 R4 nak flag still set", reply_o, 3);
              if (ep == 1) begin
                token(1, 2);
                chk("R4 shared flag ep2", reply_o, 3);
              end
              wr(0, 8'h1F);
              token(dir[0], ep[1:0]);
              chk("R2 R3 R4 data after clear", reply_o, e);
            end
          end

    // ACK without pending transaction sets nothing
    wr(0, 8'h1F); wr(1, 8'h00);
    token(1, 0); complete(1);
    rd(0, d); chk("R1 no pending no flag", d[0], 0);

    // R11 set wins over clear
    wr(1, 8'h01); token(1, 0);
    @(negedge clk_i); host_ack_i = 1; reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h01;
    @(negedge clk_i); host_ack_i = 0; reg_we_i = 0;
    rd(0, d); chk("R11 set wins", d[0], 1);
    wr(0, 8'h01); rd(0, d); chk("R11 w1c clears", d[0], 0);

    // R5 end of packet
    @(negedge clk_i); eop_i = 1; @(negedge clk_i); eop_i = 0;
    repeat (3) @(negedge clk_i);
    rd(0, d); chk("R5 eop held", d[3], 1);

    // R6 resume only in suspend
    @(negedge clk_i); bus_act_i = 1; @(negedge clk_i); bus_act_i = 0;
    rd(0, d); chk("R6 no resume awake", d[4], 0);
    suspend_i = 1;
    @(negedge clk_i); bus_act_i = 1; @(negedge clk_i); bus_act_i = 0;
    rd(0, d); chk("R6 resume in suspend", d[4], 1);
    suspend_i = 0;

    // R9 masked irq, one cycle after flag change
    wr(0, 8'h1F); wr(2, 8'h08);
    chk("R9 irq low", irq_o, 0);
    @(negedge clk_i); bus_act_i = 1; suspend_i = 1;
    @(negedge clk_i); bus_act_i = 0; suspend_i = 0;
    chk("R9 unmasked resume no irq", irq_o, 0);
    @(negedge clk_i); eop_i = 1;
    @(negedge clk_i); eop_i = 0;
    chk("R9 irq latency", irq_o, 0);
    @(negedge clk_i);
    chk("R9 irq set", irq_o, 1);
    wr(0, 8'h08);
    @(negedge clk_i);
    chk("R9 irq cleared", irq_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule